// File: doc/BRIEF.md
# Signed Sequential Multiply-Add Unit

This block computes `p = a*x + y` over several clock cycles. It consumes one bit of the multiplier per clock, starting with the least significant bit. All three operands are K bits wide and the result is 2K bits wide. Each step adds either zero or the multiplicand into the upper half of an accumulator and then shifts the whole accumulator right by one place. The multiplier sits in the lower half of the same register. Each cycle its lowest bit is used up and one finished product bit enters from the top. The addend is not added in a separate pass. It is loaded as the starting value of the upper half, so the multiply-add takes no more cycles than a plain multiply.

A parameter chooses between two's-complement and unsigned arithmetic. In two's-complement mode:
- the adder works on K+1 bits, with both inputs extended by their sign bit;
- the shift copies the sign of the sum into the top bit;
- when the multiplier is negative, its top bit carries negative weight, so the final step subtracts the multiplicand instead of adding it.

In unsigned mode, the carry out of the K+1-bit sum is what gets shifted in.

A caller pulses `start_i` with the operands valid and waits for the one-cycle `done_o` pulse. The product stays on `p_o` until the next operation is accepted.

Top module: `seq_mul_add`

## Requirements
- R1: After reset, `done_o` is 0 and `p_o` is all zeros.
- R2: A `start_i` sampled high at a clock edge while idle launches an operation. `done_o` is high for exactly one cycle, beginning K clock edges after the launching edge.
- R3: In signed mode with a non-negative multiplier, `p_o` equals `a*x + y`, taking all three inputs as K-bit two's complement and the result as 2K-bit two's complement.
- R4: In signed mode with a negative multiplier (bit K-1 of `x_i` is 1), `p_o` is still `a*x + y`. This includes the most negative value times the most negative value, with and without a non-zero addend.
- R5: The addend `y_i` is read as a K-bit two's-complement value in signed mode and as an unsigned value in unsigned mode. It enters the result with weight 1.
- R6: In unsigned mode, `p_o` equals `a*x + y` with all inputs unsigned. This includes all-ones operands.
- R7: A `start_i` pulse while an operation is in flight changes neither that operation's result nor the cycle in which its `done_o` appears.
- R8: While idle and with no `start_i`, `p_o` keeps the last result.
- R9: A zero multiplier yields `y` extended to 2K bits, using sign extension in signed mode and zero extension in unsigned mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches an operation when the unit is idle |
| a_i | input | K | Multiplicand |
| x_i | input | K | Multiplier |
| y_i | input | K | Addend |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| p_o | output | 2K | Product plus addend |

## Verification
The assertions assume two things:
- the operands are valid and stable in the cycle `start_i` is sampled;
- `rst_ni` is released away from a clock edge.

They make no assumption about `start_i` during a busy phase. The stimulus changes inputs only on falling edges and holds operands for exactly one cycle around each start. The stimulus raises `start_i` deliberately mid-operation, with different operands, to exercise the ignore path. The signed and unsigned variants receive identical bit patterns, so every operand set checks both interpretations.

// File: rtl/seq_mac_pkg.sv
package seq_mac_pkg;

  typedef enum logic {
    ARITH_UNSIGNED = 1'b0,
    ARITH_SIGNED   = 1'b1
  } arith_mode_e;

endpackage

// File: rtl/seq_mac_ctrl.sv
module seq_mac_ctrl #(
  parameter int unsigned K = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic done_o
);

  localparam int unsigned CW = (K > 1) ? $clog2(K) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(K - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign load_o = start_i & ~busy_q;
  assign step_o = busy_q;
  assign last_o = busy_q & (cnt_q == LAST_CNT);
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_o;
      if (load_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (last_o) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R2
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> done_o); // R2
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && start_i && !last_o) |=> (step_o && !done_o)); // R7
  AST_CNT_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && !last_o) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2

endmodule

// File: rtl/seq_mac_addsub.sv
module seq_mac_addsub
  import seq_mac_pkg::*;
#(
  parameter int unsigned K    = 8,
  parameter arith_mode_e MODE = ARITH_SIGNED
) (
  input  logic [K-1:0] acc_hi_i,
  input  logic [K-1:0] mcand_i,
  input  logic         add_en_i,
  input  logic         sub_en_i,
  output logic [K:0]   sum_o
);

  localparam int unsigned W = K + 1;

  logic [W-1:0] hi_ext;
  logic [W-1:0] a_ext;
  logic [W-1:0] opnd;
  logic         cin;

  // one extra bit: sign copy in signed mode, zero in unsigned mode
  generate
    if (MODE == ARITH_SIGNED) begin : g_sext
      assign hi_ext = {acc_hi_i[K-1], acc_hi_i};
      assign a_ext  = {mcand_i[K-1], mcand_i};
    end else begin : g_zext
      assign hi_ext = {1'b0, acc_hi_i};
      assign a_ext  = {1'b0, mcand_i};
    end
  endgenerate

  always_comb begin
    opnd = '0;
    cin  = 1'b0;
    if (sub_en_i) begin
      opnd = ~a_ext;
      cin  = 1'b1;
    end else if (add_en_i) begin
      opnd = a_ext;
    end
  end

  assign sum_o = hi_ext + opnd + W'(cin);

endmodule

// File: rtl/seq_mac_acc.sv
module seq_mac_acc #(
  parameter int unsigned K = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [K-1:0]   x_i,
  input  logic [K-1:0]   y_i,
  input  logic [K:0]     sum_i,
  output logic [K-1:0]   hi_o,
  output logic           mbit_o,
  output logic [2*K-1:0] prod_o
);

  logic [K-1:0] hi_q;
  logic [K-1:0] lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (load_i) begin
      hi_q <= y_i;
      lo_q <= x_i;
    end else if (step_i) begin
      // shift right: sum bit 0 becomes a finished product bit
      hi_q <= sum_i[K:1];
      lo_q <= {sum_i[0], lo_q[K-1:1]};
    end
  end

  assign hi_o   = hi_q;
  assign mbit_o = lo_q[0];
  assign prod_o = {hi_q, lo_q};

  AST_LOAD_OPERANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (hi_q == $past(y_i) && lo_q == $past(x_i))); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(prod_o)); // R8

endmodule

// File: rtl/seq_mul_add.sv
module seq_mul_add
  import seq_mac_pkg::*;
#(
  parameter int unsigned K    = 8,
  parameter arith_mode_e MODE = ARITH_SIGNED
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [K-1:0]   a_i,
  input  logic [K-1:0]   x_i,
  input  logic [K-1:0]   y_i,
  output logic           done_o,
  output logic [2*K-1:0] p_o
);

  logic         load, step, last;
  logic         mbit;
  logic [K-1:0] hi;
  logic [K:0]   sum;
  logic         add_en, sub_en;

  seq_mac_ctrl #(.K(K)) ctrl_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .last_o (last),
    .done_o (done_o)
  );

  // a negative multiplier's top bit has negative weight: subtract on the last step
  generate
    if (MODE == ARITH_SIGNED) begin : g_neg_msb
      assign sub_en = step & last & mbit;
    end else begin : g_pos_msb
      assign sub_en = 1'b0;
    end
  endgenerate
  assign add_en = step & mbit & ~sub_en;

  seq_mac_addsub #(.K(K), .MODE(MODE)) addsub_i (
    .acc_hi_i(hi),
    .mcand_i (a_i_q),
    .add_en_i(add_en),
    .sub_en_i(sub_en),
    .sum_o   (sum)
  );

  seq_mac_acc #(.K(K)) acc_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .step_i (step),
    .x_i    (x_i),
    .y_i    (y_i),
    .sum_i  (sum),
    .hi_o   (hi),
    .mbit_o (mbit),
    .prod_o (p_o)
  );

  // multiplicand captured at start so the caller may change a_i afterwards
  logic [K-1:0] a_i_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   a_i_q <= '0;
    else if (load) a_i_q <= a_i;
  end

  AST_MCAND_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !load) |=> $stable(a_i_q)); // R7
  AST_NO_SUB_UNSIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MODE == ARITH_UNSIGNED) |-> !sub_en); // R6
  AST_SUB_LAST_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_en |=> done_o); // R4

endmodule

// File: tb/seq_mul_add_tb_top.sv
module seq_mul_add_tb_top;
  import seq_mac_pkg::*;

  localparam int unsigned K = 8;
  localparam int unsigned PW = 2 * K;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [K-1:0]  a = '0, x = '0, y = '0;
  logic          done_s, done_u;
  logic [PW-1:0] p_s, p_u;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  seq_mul_add #(.K(K), .MODE(ARITH_SIGNED)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .a_i(a), .x_i(x), .y_i(y), .done_o(done_s), .p_o(p_s)
  );

  seq_mul_add #(.K(K), .MODE(ARITH_UNSIGNED)) dut_u_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .a_i(a), .x_i(x), .y_i(y), .done_o(done_u), .p_o(p_u)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] ref_s(logic [K-1:0] ia, logic [K-1:0] ix, logic [K-1:0] iy);
    longint sa, sx, sy;
    sa = longint'($signed(ia));
    sx = longint'($signed(ix));
    sy = longint'($signed(iy));
    return PW'(sa * sx + sy);
  endfunction

  function automatic logic [PW-1:0] ref_u(logic [K-1:0] ia, logic [K-1:0] ix, logic [K-1:0] iy);
    longint ua, ux, uy;
    ua = longint'(ia);
    ux = longint'(ix);
    uy = longint'(iy);
    return PW'(ua * ux + uy);
  endfunction

  // launch at a falling edge, optionally poke start again mid-flight, then check
  task automatic run_op(string req, logic [K-1:0] ia, logic [K-1:0] ix, logic [K-1:0] iy,
                        int poke_at);
    int cyc;
    int done_cnt;
    bit seen;
    logic [PW-1:0] es, eu;
    es = ref_s(ia, ix, iy);
    eu = ref_u(ia, ix, iy);
    @(negedge clk);
    a = ia; x = ix; y = iy; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    a = ~ia; x = ~ix; y = ~iy;
    cyc = 1;
    done_cnt = 0;
    seen = 1'b0;
    while (cyc < 4 * K && !seen) begin
      if (cyc == poke_at) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc++;
      if (done_s) begin
        seen = 1'b1;
        done_cnt++;
      end
    end
    chk({req, " R2 latency"}, 64'(cyc), 64'(K + 1));
    chk({req, " R2 unsigned variant done"}, 64'(done_u), 64'd1);
    chk({req, " signed result"}, 64'(p_s), 64'(es));
    chk({req, " unsigned result"}, 64'(p_u), 64'(eu));
    @(negedge clk);
    chk({req, " R2 done single cycle"}, 64'(done_s), 64'd0);
  endtask

  task automatic t_reset;
    chk("R1 done after reset", 64'(done_s), 64'd0);
    chk("R1 product after reset", 64'(p_s), 64'd0);
    chk("R1 unsigned product after reset", 64'(p_u), 64'd0);
  endtask

  task automatic t_positive;
    run_op("R3 small", 8'd5, 8'd7, 8'd0, 0);
    run_op("R3 neg mcand", 8'hF3, 8'd100, 8'd0, 0);
    run_op("R3 max", 8'd127, 8'd127, 8'd127, 0);
  endtask

  task automatic t_negative;
    run_op("R4 minus one sq", 8'hFF, 8'hFF, 8'd0, 0);
    run_op("R4 min times min", 8'h80, 8'h80, 8'd0, 0);
    run_op("R4 min min add", 8'h80, 8'h80, 8'h80, 0);
    run_op("R4 max times min", 8'd127, 8'h80, 8'd127, 0);
  endtask

  task automatic t_addend;
    run_op("R5 neg addend", 8'd3, 8'd4, 8'hF6, 0);
    run_op("R5 pos addend", 8'hFD, 8'hFC, 8'd90, 0);
  endtask

  task automatic t_unsigned;
    run_op("R6 all ones", 8'hFF, 8'hFF, 8'hFF, 0);
    run_op("R6 high bits", 8'h81, 8'hC0, 8'h01, 0);
  endtask

  task automatic t_busy_ignore;
    run_op("R7 poke early", 8'd33, 8'hE5, 8'd12, 2);
    run_op("R7 poke late", 8'h9A, 8'd77, 8'hC1, K - 1);
  endtask

  task automatic t_hold;
    logic [PW-1:0] es;
    es = ref_s(8'd21, 8'hEE, 8'd3);
    run_op("R8 setup", 8'd21, 8'hEE, 8'd3, 0);
    a = 8'h55; x = 8'hAA; y = 8'h0F;
    repeat (5) @(negedge clk);
    chk("R8 held", 64'(p_s), 64'(es));
    chk("R8 no done", 64'(done_s), 64'd0);
  endtask

  task automatic t_zero;
    run_op("R9 zero mult neg y", 8'd99, 8'd0, 8'hFB, 0);
    run_op("R9 zero mult pos y", 8'h80, 8'd0, 8'd77, 0);
  endtask

  task automatic t_random;
    for (int i = 0; i < 40; i++) begin
      run_op("R3 R4 R6 random", K'($urandom), K'($urandom), K'($urandom), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_positive();
    t_negative();
    t_addend();
    t_unsigned();
    t_busy_ignore();
    t_hold();
    t_zero();
    t_random();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

endmodule